// File: doc/BRIEF.md
# Reset-started subroutine call between two state machines

This block is a small two-machine datapath. A sequencing machine (the caller) runs a fixed program, and a second machine (the callee) adds two 32-bit words. The caller uses the callee as a shared subroutine. It does not start the callee with a start or valid strobe. Instead it writes the two argument registers, holds the callee's reset input high for one cycle to send it to its entry state, and then busy-waits in a wait state reserved for that call. When the callee raises its one-cycle done pulse, the caller leaves the wait state and reads the callee's result register.

The program loads constant `OP_A`, then constant `OP_B`, and calls the adder on them. It stores the partial sum, loads constant `OP_C`, calls the adder a second time on the partial sum and `OP_C`, and returns the final word on `ret` with a one-cycle `fin` pulse. The state codes of both machines and the handshake lines are brought out as observation ports, so that every step of the call protocol can be checked at the boundary.

Top module: `callhs_top`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, the outputs are as follows. The caller state is 9, the callee state is 3 (idle), `fin`, `obs_call_rst` and `obs_call_done` are 0, and `ret` and `obs_callee_ret` are 0.
- R2: After reset the caller steps through states 9, 8 and 7, one clock each. State 7 is the first call site.
- R3: In each call state (7, then 4) the caller loads both argument registers and drives the callee reset `obs_call_rst` high for exactly one cycle. On the following edge the callee is in entry state 2.
- R4: The caller waits in state 12 after the first call and in state 10 after the second. It holds that state while `obs_call_done` is low and leaves on the edge after `obs_call_done` is high, going to 6 from state 12 and to 3 from state 10.
- R5: After entry, the callee goes 2 → 1 → 3. Leaving state 1, it raises `obs_call_done` for exactly one cycle. It then stays in idle state 3 with `obs_call_done` low until it is next reset.
- R6: The callee's result register `obs_callee_ret` becomes `OP_A+OP_B` after the first call and `OP_A+OP_B+OP_C` after the second, with the arithmetic taken modulo 2^32.
- R7: After the first return the caller passes through 6, 5 and 4. After the second return it passes through 3, 2 and 1 and then stays in state 11. `fin` is high for exactly one cycle, 17 edges after reset release, with `ret = OP_A+OP_B+OP_C` mod 2^32.
- R8: `ret` keeps its value in every cycle except the cycle in which `fin` is raised, until the next reset.
- R9: Asserting `rst` at any point, including while a call is in flight, returns both machines to the state of R1. The whole sequence then repeats with the same timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset for both machines |
| ret | output | 32 | Program result, valid from the `fin` pulse onwards |
| fin | output | 1 | One-cycle program-complete pulse |
| obs_caller_state | output | 32 | Caller state code |
| obs_callee_state | output | 32 | Callee state code |
| obs_call_rst | output | 1 | Caller-driven reset into the callee (call start) |
| obs_call_done | output | 1 | Callee one-cycle done pulse (call return) |
| obs_callee_ret | output | 32 | Callee result register |

## Verification
The bench goes after the wait-state edges. A caller that sampled the done pulse one cycle late, or that left the wait state on the pulse's own edge, would shift every later state and move `fin` away from edge 17. It also checks that the call-start pulse drops on entry to the wait state: a reset line left high would pin the callee in state 2 and the program would hang. The default constants force the first sum to wrap past 2^32, which exposes a narrow or signed adder. A reset applied while the callee is mid-call must clear its result and return it to idle; if it does not, stale sums or an extra done pulse appear after the restart.

// File: rtl/callhs_pkg.sv
package callhs_pkg;
  // caller state codes
  localparam int unsigned CR_LOAD_A   = 9;
  localparam int unsigned CR_LOAD_B   = 8;
  localparam int unsigned CR_CALL1    = 7;
  localparam int unsigned CR_WAIT1    = 12;
  localparam int unsigned CR_TAKE1    = 6;
  localparam int unsigned CR_LOAD_C   = 5;
  localparam int unsigned CR_CALL2    = 4;
  localparam int unsigned CR_WAIT2    = 10;
  localparam int unsigned CR_TAKE2    = 3;
  localparam int unsigned CR_MOVE     = 2;
  localparam int unsigned CR_RETURN   = 1;
  localparam int unsigned CR_HALT     = 11;
  // callee state codes
  localparam int unsigned CE_ENTRY    = 2;
  localparam int unsigned CE_COMPUTE  = 1;
  localparam int unsigned CE_IDLE     = 3;
endpackage

// File: rtl/callhs_adder_callee.sv
module callhs_adder_callee #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned STATE_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               call_rst,
  input  logic [DATA_W-1:0]  arg_p,
  input  logic [DATA_W-1:0]  arg_q,
  output logic               done,
  output logic [DATA_W-1:0]  result,
  output logic [STATE_W-1:0] state
);
  import callhs_pkg::*;

  localparam logic [STATE_W-1:0] S_ENTRY   = STATE_W'(CE_ENTRY);
  localparam logic [STATE_W-1:0] S_COMPUTE = STATE_W'(CE_COMPUTE);
  localparam logic [STATE_W-1:0] S_IDLE    = STATE_W'(CE_IDLE);

  function automatic logic [DATA_W-1:0] add_words(input logic [DATA_W-1:0] x,
                                                  input logic [DATA_W-1:0] y);
    return x + y;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= S_IDLE;
      done   <= 1'b0;
      result <= '0;
    end else if (call_rst) begin
      state <= S_ENTRY;
      done  <= 1'b0;
    end else begin
      case (state)
        S_ENTRY: begin
          state <= S_COMPUTE;
          done  <= 1'b0;
        end
        S_COMPUTE: begin
          result <= add_words(arg_p, arg_q);
          done   <= 1'b1;
          state  <= S_IDLE;
        end
        default: begin
          state <= S_IDLE;
          done  <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/callhs_caller.sv
module callhs_caller #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned STATE_W = 32,
  parameter logic [DATA_W-1:0] OP_A = '0,
  parameter logic [DATA_W-1:0] OP_B = '0,
  parameter logic [DATA_W-1:0] OP_C = '0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               callee_done,
  input  logic [DATA_W-1:0]  callee_result,
  output logic               callee_rst,
  output logic [DATA_W-1:0]  arg_p,
  output logic [DATA_W-1:0]  arg_q,
  output logic               fin,
  output logic [DATA_W-1:0]  ret,
  output logic [STATE_W-1:0] state
);
  import callhs_pkg::*;

  localparam logic [STATE_W-1:0] S_LOAD_A = STATE_W'(CR_LOAD_A);
  localparam logic [STATE_W-1:0] S_LOAD_B = STATE_W'(CR_LOAD_B);
  localparam logic [STATE_W-1:0] S_CALL1  = STATE_W'(CR_CALL1);
  localparam logic [STATE_W-1:0] S_WAIT1  = STATE_W'(CR_WAIT1);
  localparam logic [STATE_W-1:0] S_TAKE1  = STATE_W'(CR_TAKE1);
  localparam logic [STATE_W-1:0] S_LOAD_C = STATE_W'(CR_LOAD_C);
  localparam logic [STATE_W-1:0] S_CALL2  = STATE_W'(CR_CALL2);
  localparam logic [STATE_W-1:0] S_WAIT2  = STATE_W'(CR_WAIT2);
  localparam logic [STATE_W-1:0] S_TAKE2  = STATE_W'(CR_TAKE2);
  localparam logic [STATE_W-1:0] S_MOVE   = STATE_W'(CR_MOVE);
  localparam logic [STATE_W-1:0] S_RETURN = STATE_W'(CR_RETURN);
  localparam logic [STATE_W-1:0] S_HALT   = STATE_W'(CR_HALT);

  logic [DATA_W-1:0] v_a, v_b, v_s1, v_c, v_s2, v_res;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_LOAD_A;
      fin        <= 1'b0;
      ret        <= '0;
      callee_rst <= 1'b0;
      arg_p      <= '0;
      arg_q      <= '0;
      v_a        <= '0;
      v_b        <= '0;
      v_s1       <= '0;
      v_c        <= '0;
      v_s2       <= '0;
      v_res      <= '0;
    end else begin
      callee_rst <= 1'b0;
      fin        <= 1'b0;
      case (state)
        S_LOAD_A: begin v_a <= OP_A; state <= S_LOAD_B; end
        S_LOAD_B: begin v_b <= OP_B; state <= S_CALL1; end
        S_CALL1: begin
          arg_p      <= v_a;
          arg_q      <= v_b;
          callee_rst <= 1'b1;
          state      <= S_WAIT1;
        end
        S_WAIT1:  if (callee_done) state <= S_TAKE1;
        S_TAKE1:  begin v_s1 <= callee_result; state <= S_LOAD_C; end
        S_LOAD_C: begin v_c <= OP_C; state <= S_CALL2; end
        S_CALL2: begin
          arg_p      <= v_s1;
          arg_q      <= v_c;
          callee_rst <= 1'b1;
          state      <= S_WAIT2;
        end
        S_WAIT2:  if (callee_done) state <= S_TAKE2;
        S_TAKE2:  begin v_s2 <= callee_result; state <= S_MOVE; end
        S_MOVE:   begin v_res <= v_s2; state <= S_RETURN; end
        S_RETURN: begin ret <= v_res; fin <= 1'b1; state <= S_HALT; end
        default:  state <= S_HALT;
      endcase
    end
  end
endmodule

// File: rtl/callhs_top.sv
module callhs_top #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned STATE_W = 32,
  parameter logic [DATA_W-1:0] OP_A = 32'hFFFF_FFF0,
  parameter logic [DATA_W-1:0] OP_B = 32'h0000_0025,
  parameter logic [DATA_W-1:0] OP_C = 32'h0000_0007
) (
  input  logic               clk,
  input  logic               rst,
  output logic [DATA_W-1:0]  ret,
  output logic               fin,
  output logic [STATE_W-1:0] obs_caller_state,
  output logic [STATE_W-1:0] obs_callee_state,
  output logic               obs_call_rst,
  output logic               obs_call_done,
  output logic [DATA_W-1:0]  obs_callee_ret
);
  // internal events as named wires
  logic              call_launch;
  logic              call_return;
  logic [DATA_W-1:0] arg_p;
  logic [DATA_W-1:0] arg_q;
  logic [DATA_W-1:0] callee_sum;

  callhs_caller #(
    .DATA_W(DATA_W), .STATE_W(STATE_W),
    .OP_A(OP_A), .OP_B(OP_B), .OP_C(OP_C)
  ) u_caller (
    .clk(clk), .rst(rst),
    .callee_done(call_return), .callee_result(callee_sum),
    .callee_rst(call_launch), .arg_p(arg_p), .arg_q(arg_q),
    .fin(fin), .ret(ret), .state(obs_caller_state)
  );

  callhs_adder_callee #(
    .DATA_W(DATA_W), .STATE_W(STATE_W)
  ) u_callee (
    .clk(clk), .rst(rst), .call_rst(call_launch),
    .arg_p(arg_p), .arg_q(arg_q),
    .done(call_return), .result(callee_sum), .state(obs_callee_state)
  );

  assign obs_call_rst   = call_launch;
  assign obs_call_done  = call_return;
  assign obs_callee_ret = callee_sum;
endmodule

// File: rtl/callhs_checker.sv
module callhs_checker #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned STATE_W = 32
) (
  input logic               clk,
  input logic               rst,
  input logic [DATA_W-1:0]  ret,
  input logic               fin,
  input logic [STATE_W-1:0] obs_caller_state,
  input logic [STATE_W-1:0] obs_callee_state,
  input logic               obs_call_rst,
  input logic               obs_call_done
);
  import callhs_pkg::*;

  // R3
  call_rst_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    obs_call_rst |=> !obs_call_rst);
  // R3
  callee_entry_chk: assert property (@(posedge clk) disable iff (rst)
    obs_call_rst |=> obs_callee_state == STATE_W'(CE_ENTRY));
  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    obs_call_done |=> !obs_call_done);
  // R5
  compute_done_chk: assert property (@(posedge clk) disable iff (rst)
    (obs_callee_state == STATE_W'(CE_COMPUTE) && !obs_call_rst) |=> obs_call_done);
  // R4
  wait1_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (obs_caller_state == STATE_W'(CR_WAIT1) && !obs_call_done)
      |=> obs_caller_state == STATE_W'(CR_WAIT1));
  // R4
  wait1_leave_chk: assert property (@(posedge clk) disable iff (rst)
    (obs_caller_state == STATE_W'(CR_WAIT1) && obs_call_done)
      |=> obs_caller_state == STATE_W'(CR_TAKE1));
  // R4
  wait2_leave_chk: assert property (@(posedge clk) disable iff (rst)
    (obs_caller_state == STATE_W'(CR_WAIT2) && obs_call_done)
      |=> obs_caller_state == STATE_W'(CR_TAKE2));
  // R7
  fin_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    fin |=> !fin);
  // R7
  fin_halt_chk: assert property (@(posedge clk) disable iff (rst)
    fin |-> obs_caller_state == STATE_W'(CR_HALT));
  // R8
  ret_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!fin && !$past(rst)) |-> $stable(ret));
endmodule

bind callhs_top callhs_checker #(.DATA_W(DATA_W), .STATE_W(STATE_W)) u_chk (
  .clk(clk), .rst(rst), .ret(ret), .fin(fin),
  .obs_caller_state(obs_caller_state), .obs_callee_state(obs_callee_state),
  .obs_call_rst(obs_call_rst), .obs_call_done(obs_call_done)
);

// File: tb/tb_callhs_top.sv
module tb_callhs_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  localparam logic [31:0] A1 = 32'hFFFF_FFF0, B1 = 32'h0000_0025, C1 = 32'h0000_0007;
  localparam logic [31:0] A2 = 32'd5, B2 = 32'd10, C2 = 32'd100;

  logic [31:0] ret, ret2, cst, est, cret, cst2, est2, cret2;
  logic fin, crst, cdone, fin2, crst2, cdone2;

  callhs_top dut (.clk(clk), .rst(rst), .ret(ret), .fin(fin),
    .obs_caller_state(cst), .obs_callee_state(est), .obs_call_rst(crst),
    .obs_call_done(cdone), .obs_callee_ret(cret));

  callhs_top #(.OP_A(A2), .OP_B(B2), .OP_C(C2)) dut2 (.clk(clk), .rst(rst),
    .ret(ret2), .fin(fin2), .obs_caller_state(cst2), .obs_callee_state(est2),
    .obs_call_rst(crst2), .obs_call_done(cdone2), .obs_callee_ret(cret2));

  int checks = 0, failures = 0;
  int n = 0;           // edges since reset release
  bit started = 0;
  bit second_run = 0;
  int caller_seq[$];   // expected caller state after edge n

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s n=%0d actual=%0h expected=%0h", req, what, n, act, exp);
    end
  endtask

  function automatic int exp_callee(input int k);
    // call-start pulses at k=3 and k=10; callee entry one edge later
    if (k == 4 || k == 11) return 2;
    if (k == 5 || k == 12) return 1;
    return 3;
  endfunction

  always @(posedge clk) begin
    started = 1;
    if (rst) n = 0; else if (n < 100000) n++;
  end

  always @(negedge clk) begin
    if (started) begin
      string tag;
      logic [31:0] s1, s3, s1b, s3b;
      int ec;
      tag = second_run ? "R9" : "R1";
      s1 = A1 + B1; s3 = s1 + C1;
      s1b = A2 + B2; s3b = s1b + C2;
      ec = (n < caller_seq.size()) ? caller_seq[n] : 11;
      if (n == 0) begin
        chk(tag, "reset caller state", cst, 9);
        chk(tag, "reset callee state", est, 3);
        chk(tag, "reset fin", fin, 0);
        chk(tag, "reset ret", ret, 0);
        chk(tag, "reset callee ret", cret, 0);
      end
      // R2 R4 R7 caller sequence
      chk(n <= 2 ? "R2" : (ec == 12 || ec == 10) ? "R4" : "R7", "caller state", cst, ec);
      chk("R5", "callee state", est, exp_callee(n));
      chk("R3", "call rst", crst, (n == 3 || n == 10));
      chk("R5", "call done", cdone, (n == 6 || n == 13));
      chk("R7", "fin", fin, (n == 17));
      chk("R6", "callee ret", cret, n < 6 ? 0 : n < 13 ? s1 : s3);
      chk(n >= 17 ? "R7" : "R8", "ret", ret, n < 17 ? 0 : s3);
      chk("R6", "dut2 callee ret", cret2, n < 6 ? 0 : n < 13 ? s1b : s3b);
      chk("R7", "dut2 ret", ret2, n < 17 ? 0 : s3b);
      chk("R7", "dut2 fin", fin2, (n == 17));
    end
  end

  initial begin
    int wd;
    wd = 0;
    caller_seq = {9, 8, 7, 12, 12, 12, 12, 6, 5, 4, 10, 10, 10, 10, 3, 2, 1};
    fork
      begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R9: reset while the first call is in the callee's compute state
        wait (n == 5);
        @(negedge clk);
        second_run = 1;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        repeat (30) @(negedge clk);
      end
      begin
        while (wd < 5000) begin @(posedge clk); wd++; end
        failures++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule